// File: doc/BRIEF.md
# Audio Frame Sequencer

This block paces the slow envelope and length machinery of a retro-console sound unit. A fast input clock is divided down to produce sequencer steps, and a step counter runs from zero to a wrap point. Certain fixed counts produce single-cycle quarter-frame and half-frame strobes, which the sound channels consume. In four-step mode, the end of each frame also raises a frame interrupt.

The block decodes two write registers on a small offset bus. The channel-control register holds the five channel enables. The frame-control register holds the sequencer mode and an interrupt inhibit. A read of the channel-control offset returns a status byte that carries the interrupt flags and the enables. That read also acknowledges the frame interrupt. The delta-modulation channel's interrupt arrives as a plain input and is only reflected in the status byte.

Top module: `audio_frame_seq`

## Requirements
- R1: The step counter advances once every `DIV` input clocks (default 6). After reset release, the n-th step is taken at the n-th multiple of `DIV` rising edges, and it processes count n-1.
- R2: In four-step mode, `qtr_strobe` pulses for one clock at counts 3728, 7456, 11185 and 14914. `half_strobe` pulses at 7456 and 14914. Each pulse appears in the clock after the step that reaches the count.
- R3: Every half-frame strobe is accompanied by a quarter-frame strobe in the same clock.
- R4: In four-step mode, the steps at counts 14914 and 14915 each load the frame interrupt flag with the current interrupt-enable value (the inverse of inhibit). The step at 14915 wraps the counter to 0.
- R5: In five-step mode, quarter strobes occur at 3728, 7456, 11185 and 18640, and half strobes at 7456 and 18640. The counter wraps to 0 after 18640, and the frame interrupt flag is never set.
- R6: A write to offset 0x17 takes bit 7 as the mode (1 = five-step) and bit 6 as interrupt inhibit. When bit 6 is 1, the flag is clear in the next clock, even if a setting step coincides.
- R7: A write to offset 0x15 loads the enables from bits 4..0, with bit 0 for pulse 1, bit 1 for pulse 2, bit 2 for triangle, bit 3 for noise and bit 4 for delta modulation. The new enables are visible on `chan_en` in the next clock.
- R8: While `rd_en` is high with offset 0x15, `rdata` shows {dmc_irq_in, flag, 0, enables[4:0]} in the same clock. Bit 5 always reads 0. The flag is cleared in the next clock unless a setting step coincides.
- R9: `frame_irq` equals the flag level. It stays high until it is acknowledged by a status read or cleared by an inhibit write.
- R10: Reset clears the prescaler, the counter, the enables, the mode (four-step), the inhibit and the flag. With reset asserted, the strobes and `frame_irq` are low.
- R11: Writes to other offsets change nothing, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| dmc_irq_in | input | 1 | Delta-modulation interrupt level |
| chan_en | output | 5 | Channel enables |
| qtr_strobe | output | 1 | Quarter-frame pulse |
| half_strobe | output | 1 | Half-frame pulse |
| frame_irq | output | 1 | Frame interrupt flag level |

## Verification
The strobes and the interrupt flag change one clock after the step that reaches their count. Register writes and the acknowledge from a status read also take effect one clock later, while `rdata` is due in the same clock as `rd_en`. The bench drives inputs one nanosecond after a rising edge, and its reference model steps on the same edge. Every output is compared at the falling edge, so each result is checked in the clock in which it is due. To keep full frames short, the bench shrinks the divider to 3, and it measures the first strobe's edge count against `3729*DIV`.

// File: rtl/afs_pkg.sv
package afs_pkg;

  typedef enum logic {
    SEQ_FOUR = 1'b0,
    SEQ_FIVE = 1'b1
  } seq_mode_e;

  typedef struct packed {
    logic qtr;
    logic half;
    logic irq_set;
    logic wrap;
  } step_evt_t;

  localparam int unsigned OFS_CHAN  = 5'h15;
  localparam int unsigned OFS_FRAME = 5'h17;

  // status byte: dmc irq, frame irq, zero, five enables
  function automatic logic [7:0] pack_status(input logic dmc, input logic flag,
                                             input logic [4:0] en);
    return {dmc, flag, 1'b0, en};
  endfunction

  function automatic logic [4:0] pick_enables(input logic [7:0] d);
    return d[4:0];
  endfunction

  function automatic seq_mode_e pick_mode(input logic [7:0] d);
    return d[7] ? SEQ_FIVE : SEQ_FOUR;
  endfunction

endpackage

// File: rtl/afs_prescaler.sv
module afs_prescaler #(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/afs_step_seq.sv
module afs_step_seq
  import afs_pkg::*;
#(
  parameter int unsigned Q1 = 3728,
  parameter int unsigned H1 = 7456,
  parameter int unsigned Q2 = 11185,
  parameter int unsigned H4 = 14914,
  parameter int unsigned E4 = 14915,
  parameter int unsigned H5 = 18640,
  parameter int unsigned CW = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  seq_mode_e mode,
  output step_evt_t evt,
  output logic      qtr_strobe,
  output logic      half_strobe
);
  logic [CW-1:0] count;

  function automatic logic [CW-1:0] wrap_point(input seq_mode_e m);
    return (m == SEQ_FIVE) ? CW'(H5) : CW'(E4);
  endfunction

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input seq_mode_e m);
    return (c >= wrap_point(m)) ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    evt = '0;
    if (tick) begin
      evt.half = (count == CW'(H1)) ||
                 (mode == SEQ_FIVE ? count == CW'(H5) : count == CW'(H4));
      evt.qtr  = evt.half || (count == CW'(Q1)) || (count == CW'(Q2));
      evt.irq_set = (mode == SEQ_FOUR) &&
                    ((count == CW'(H4)) || (count == CW'(E4)));
      evt.wrap = (count >= wrap_point(mode));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      qtr_strobe  <= 1'b0;
      half_strobe <= 1'b0;
    end else begin
      qtr_strobe  <= evt.qtr;
      half_strobe <= evt.half;
      if (tick) count <= next_count(count, mode);
    end
  end

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R3
  half_implies_qtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_strobe |-> qtr_strobe);
  // R2
  qtr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_strobe |=> !qtr_strobe);
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wrap |=> (count == '0));

endmodule

// File: rtl/afs_ctrl_regs.sv
module afs_ctrl_regs
  import afs_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned CHAN_OFS  = OFS_CHAN,
  parameter int unsigned FRAME_OFS = OFS_FRAME
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          dmc_irq_in,
  input  logic          irq_set,
  output logic [4:0]    chan_en,
  output seq_mode_e     mode,
  output logic          irq_flag,
  output logic [7:0]    rdata
);
  logic inhibit;
  logic chan_wr, frame_wr, inhibit_wr, status_rd;

  assign chan_wr    = wr_en && (addr == AW'(CHAN_OFS));
  assign frame_wr   = wr_en && (addr == AW'(FRAME_OFS));
  assign inhibit_wr = frame_wr && wdata[6];
  assign status_rd  = rd_en && (addr == AW'(CHAN_OFS));

  assign rdata = status_rd ? pack_status(dmc_irq_in, irq_flag, chan_en) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en  <= '0;
      mode     <= SEQ_FOUR;
      inhibit  <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (chan_wr) chan_en <= pick_enables(wdata);
      if (frame_wr) begin
        mode    <= pick_mode(wdata);
        inhibit <= wdata[6];
      end
      if (inhibit_wr)     irq_flag <= 1'b0;
      else if (irq_set)   irq_flag <= !inhibit;
      else if (status_rd) irq_flag <= 1'b0;
    end
  end

  // R6
  inhibit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_wr |=> !irq_flag);
  // R8
  read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !irq_set) |=> !irq_flag);
  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(irq_set));
  // R8
  bit5_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[5] == 1'b0);
  // R11
  other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd |-> (rdata == 8'h00));

endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq
  import afs_pkg::*;
#(
  parameter int unsigned DIV = 6,
  parameter int unsigned AW  = 5,
  parameter int unsigned Q1  = 3728,
  parameter int unsigned H1  = 7456,
  parameter int unsigned Q2  = 11185,
  parameter int unsigned H4  = 14914,
  parameter int unsigned E4  = 14915,
  parameter int unsigned H5  = 18640
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          dmc_irq_in,
  output logic [4:0]    chan_en,
  output logic          qtr_strobe,
  output logic          half_strobe,
  output logic          frame_irq
);
  localparam int unsigned CW = $clog2(((H5 > E4) ? H5 : E4) + 1);

  logic      step_tick;
  seq_mode_e seq_mode;
  step_evt_t step_evt;

  afs_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(step_tick)
  );

  afs_step_seq #(
    .Q1(Q1), .H1(H1), .Q2(Q2), .H4(H4), .E4(E4), .H5(H5), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(step_tick), .mode(seq_mode),
    .evt(step_evt), .qtr_strobe(qtr_strobe), .half_strobe(half_strobe)
  );

  afs_ctrl_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .dmc_irq_in(dmc_irq_in), .irq_set(step_evt.irq_set),
    .chan_en(chan_en), .mode(seq_mode), .irq_flag(frame_irq), .rdata(rdata)
  );

  // R5
  five_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> $past(seq_mode == SEQ_FOUR));
  // R2
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qtr_strobe) |-> $past(step_tick));

endmodule

// File: tb/test_audio_frame_seq.sv
module test_audio_frame_seq;
  localparam int DIV = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, dmc_irq_in = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [4:0] chan_en;
  logic qtr_strobe, half_strobe, frame_irq;

  int errors = 0, checks = 0;
  int edges = 0;

  always #4 clk = ~clk;

  audio_frame_seq #(.DIV(DIV)) i_audio_frame_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dmc_irq_in(dmc_irq_in), .chan_en(chan_en),
    .qtr_strobe(qtr_strobe), .half_strobe(half_strobe), .frame_irq(frame_irq)
  );

  // behavioural reference model
  int m_pre, m_cnt, m_en, m_five, m_inh, m_flag, m_q, m_h;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_en = 0; m_five = 0; m_inh = 0; m_flag = 0;
      m_q = 0; m_h = 0;
    end else begin
      bit tk, setv, ack, inhw;
      int old_inh;
      edges++;
      tk = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      m_q = 0; m_h = 0; setv = 0;
      if (tk) begin
        if (m_cnt == 7456 || m_cnt == (m_five ? 18640 : 14914)) begin m_h = 1; m_q = 1; end
        if (m_cnt == 3728 || m_cnt == 11185) m_q = 1;
        setv = !m_five && (m_cnt == 14914 || m_cnt == 14915);
        m_cnt = (m_cnt >= (m_five ? 18640 : 14915)) ? 0 : m_cnt + 1;
      end
      old_inh = m_inh;
      ack  = rd_en && addr == 5'h15;
      inhw = wr_en && addr == 5'h17 && wdata[6];
      if (wr_en && addr == 5'h15) m_en = wdata[4:0];
      if (wr_en && addr == 5'h17) begin m_five = wdata[7]; m_inh = wdata[6]; end
      if (inhw) m_flag = 0;
      else if (setv) m_flag = !old_inh;
      else if (ack) m_flag = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    int exp_rd;
    exp_rd = (rd_en && addr == 5'h15) ? {dmc_irq_in, m_flag[0], 1'b0, m_en[4:0]} : 0;
    chk("R2 qtr_strobe", qtr_strobe, m_q);
    chk("R3 half_strobe", half_strobe, m_h);
    chk("R4 frame_irq", frame_irq, m_flag);
    chk("R7 chan_en", chan_en, m_en);
    chk("R8 rdata", rdata, exp_rd);
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(posedge clk); #1; rd_en = 1; addr = a;
    @(negedge clk); v = rdata;
    @(posedge clk); #1; rd_en = 0; addr = 0;
  endtask

  initial begin
    #190000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int nq, nh, first_q;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset qtr", qtr_strobe, 0);
    chk("R10 reset half", half_strobe, 0);
    chk("R10 reset irq", frame_irq, 0);
    chk("R10 reset en", chan_en, 0);
    rst_n = 1;

    // R7 enables load
    wr(5'h15, 8'hF5);
    @(negedge clk); chk("R7 enables", chan_en, 5'h15);
    // R11 other offsets
    wr(5'h16, 8'h1F);
    @(negedge clk); chk("R11 write ignored", chan_en, 5'h15);
    rd(5'h14, v); chk("R11 read other", v, 0);
    // R8 status read with dmc irq
    dmc_irq_in = 1;
    rd(5'h15, v); chk("R8 status dmc", v, 8'h95);
    dmc_irq_in = 0;

    // R1 R2 count strobes over one four-step frame
    nq = 0; nh = 0; first_q = 0;
    while (!frame_irq) begin
      @(negedge clk);
      if (qtr_strobe) begin nq++; if (first_q == 0) first_q = edges; end
      if (half_strobe) nh++;
    end
    chk("R1 first step timing", first_q, 3729 * DIV);
    chk("R2 quarter count", nq, 4);
    chk("R2 half count", nh, 2);
    repeat (20) @(negedge clk);
    chk("R9 irq held", frame_irq, 1);
    rd(5'h15, v); chk("R8 status flag", v, 8'h55);
    @(negedge clk); chk("R8 ack cleared", frame_irq, 0);

    // R6 inhibit clears pending flag
    while (!frame_irq) @(negedge clk);
    repeat (10) @(negedge clk);
    wr(5'h17, 8'h40);
    @(negedge clk); chk("R6 inhibit clear", frame_irq, 0);

    // R5 five-step mode over one full period
    wr(5'h17, 8'h80);
    nq = 0; nh = 0; v = 0;
    for (int i = 0; i < 18641 * DIV; i++) begin
      @(negedge clk);
      if (qtr_strobe) nq++;
      if (half_strobe) nh++;
      if (frame_irq) v = 1;
    end
    chk("R5 quarter count", nq, 4);
    chk("R5 half count", nh, 2);
    chk("R5 no irq", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule